// File: doc/BRIEF.md
# SMBus Host Transaction Sequencer

This core is the transaction layer of an SMBus host. Software fills a small byte-wide register file with a target address, a command code and data, then writes the control register with a transaction type and the start bit. The core walks the transaction one bus byte at a time. It asks an external byte engine to emit a start condition, write a byte, read a byte with ACK or NACK, or emit a stop, and it waits for each step to complete. Per-transaction outcomes are reported in a status register whose flags software clears by writing ones.

Block transfers are paced by software. After every data byte the core raises a byte-done flag and stalls until software clears it. On writes, software refills the block-data register before clearing. On reads, software collects the byte before clearing. A raw I2C block read has no length byte. It runs until software sets the last-byte control bit; the core then NACKs the next byte and closes the bus.

Top module: `smb_host_seq`

## Requirements
- R1: After reset every register reads 0x00, at offsets 0 status, 1 control, 2 command, 3 address, 4 data0, 5 data1, 6 block data and 7 unused. No engine request is raised and irq is low.
- R2: Writing control with bit 6 set starts a transaction only when host busy (status bit 0) is clear. A start written while busy is ignored. Bit 6 always reads back as 0, and busy reads 1 while a transaction runs.
- R3: A quick transaction (control bits 4:2 = 0) issues start, a write of the address register as loaded, and stop. Engine ops are encoded 0 start, 1 write, 2 read, 3 stop. On completion busy clears and the done flag (status bit 1) is set.
- R4: A byte-data write (type 2) issues start, the address byte {addr[7:1],0}, the command, data0 and stop.
- R5: A word-data read (type 3, address bit 0 = 1) issues start, {addr[7:1],0}, the command, a repeated start and {addr[7:1],1}. It then reads one byte with ACK into data0 and one byte with NACK into data1, followed by stop.
- R6: A block write (type 5, address bit 0 = 0) sends the command, then the count from data0 clipped to MAX_BLOCK, then that many block-data bytes. After each byte it sets byte done (status bit 7) and issues nothing more until software clears that bit.
- R7: A block read (type 5, address bit 0 = 1) reads the count byte with ACK into data0, clipped to MAX_BLOCK. It then reads that many bytes into the block-data register, with the same byte-done handshake. Only the last byte is NACKed.
- R8: An I2C block read (type 6) sends data1 as the offset after the write address, restarts with the read address, and reads bytes with ACK. Once the last-byte bit (control bit 5) is set, the next byte is NACKed and a stop follows. The core clears the last-byte bit at the end.
- R9: A NACK on any written byte (address or data) sets device error (status bit 4 stays clear; bit 2 is set), issues stop and ends the transaction without setting the done flag.
- R10: An engine fault sets bus error (status bit 3) and ends the transaction at once, with no stop issued.
- R11: A kill request (control bit 1) sets failed (status bit 4), issues stop and ends the transaction.
- R12: Status bits 7, 4, 3, 2 and 1 clear when written with 1; writing 0 leaves them unchanged.
- R13: irq equals interrupt enable (control bit 0) AND any of status bits 4:1.
- R14: Type codes 4 and 7 set device error and end the transaction with no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| irq | output | 1 | Interrupt request |
| eng_req | output | 1 | Byte-engine operation request, held until eng_done |
| eng_op | output | 2 | Operation: 0 start, 1 write, 2 read, 3 stop |
| eng_wdata | output | 8 | Byte to write |
| eng_nack | output | 1 | For reads: answer the byte with NACK |
| eng_done | input | 1 | Operation complete (one cycle) |
| eng_nak | input | 1 | With eng_done: the written byte was not acknowledged |
| eng_fault | input | 1 | With eng_done: the engine detected a bus fault |
| eng_rdata | input | 8 | With eng_done: byte read from the bus |

## Verification
The bench builds the core with MAX_BLOCK set to 4 instead of 32. This keeps block handshake loops short and brings count clipping within reach: a block write loaded with a count of 6 must send a count of 4 and exactly four data bytes. A bench byte-engine model logs every requested operation, so the full op sequence of each transaction type is compared entry by entry. The same model injects NACKs, faults and read data at chosen op positions.

// File: rtl/smb_host_pkg.sv
package smb_host_pkg;

    // register offsets
    localparam logic [2:0] REG_STAT = 3'd0;
    localparam logic [2:0] REG_CTL  = 3'd1;
    localparam logic [2:0] REG_CMD  = 3'd2;
    localparam logic [2:0] REG_ADDR = 3'd3;
    localparam logic [2:0] REG_D0   = 3'd4;
    localparam logic [2:0] REG_D1   = 3'd5;
    localparam logic [2:0] REG_BLK  = 3'd6;

    // control bit positions
    localparam int CTL_IE    = 0;
    localparam int CTL_KILL  = 1;
    localparam int CTL_LAST  = 5;
    localparam int CTL_START = 6;

    // transaction type codes (control bits 4:2)
    localparam logic [2:0] T_QUICK = 3'd0;
    localparam logic [2:0] T_BYTE  = 3'd1;
    localparam logic [2:0] T_BDATA = 3'd2;
    localparam logic [2:0] T_WORD  = 3'd3;
    localparam logic [2:0] T_BLOCK = 3'd5;
    localparam logic [2:0] T_I2CRD = 3'd6;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_STOP  = 2'd3
    } eng_op_e;

    typedef enum logic [1:0] {
        END_OK   = 2'd0,
        END_DEV  = 2'd1,
        END_BUS  = 2'd2,
        END_FAIL = 2'd3
    } end_e;

    typedef enum logic [4:0] {
        S_IDLE, S_START1, S_ADDR1, S_CMD, S_OFS, S_RESTART, S_ADDR2,
        S_WD0, S_WD1, S_WCNT, S_WBLK, S_RD0, S_RD1, S_RCNT, S_RBLK,
        S_HOLD, S_STOP, S_END
    } seq_state_e;

endpackage

// File: rtl/smb_host_regs.sv
module smb_host_regs
    import smb_host_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       start_o,
    output logic [2:0] start_type_o,
    output logic       last_o,
    output logic       kill_o,
    output logic [7:0] cmd_o,
    output logic [7:0] addr_o,
    output logic [7:0] d0_o,
    output logic [7:0] d1_o,
    output logic [7:0] blk_o,
    output logic [7:0] status_o,
    output logic       irq_o,
    input  logic       set_byte_done,
    input  logic       fin,
    input  end_e       fin_kind,
    input  logic       d0_we,
    input  logic       d1_we,
    input  logic       blk_we,
    input  logic [7:0] fsm_wval
);

    logic [7:0] ctl_q, cmd_q, addr_q, d0_q, d1_q, blk_q;
    logic       bd_q, fail_q, bus_q, dev_q, intr_q, busy_q;
    logic [7:0] hit;

    assign hit          = wr_en ? (8'b1 << wr_addr) : 8'h00;
    assign start_o      = hit[REG_CTL] && wr_data[CTL_START] && !busy_q;
    assign start_type_o = wr_data[4:2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= '0; cmd_q <= '0; addr_q <= '0;
            d0_q   <= '0; d1_q  <= '0; blk_q  <= '0;
            bd_q   <= 1'b0; fail_q <= 1'b0; bus_q <= 1'b0;
            dev_q  <= 1'b0; intr_q <= 1'b0; busy_q <= 1'b0;
        end else begin
            if (hit[REG_CTL])  ctl_q  <= wr_data & ~(8'h01 << CTL_START);
            if (fin)           ctl_q[CTL_LAST] <= 1'b0;
            if (hit[REG_CMD])  cmd_q  <= wr_data;
            if (hit[REG_ADDR]) addr_q <= wr_data;
            if (d0_we)             d0_q  <= fsm_wval;
            else if (hit[REG_D0])  d0_q  <= wr_data;
            if (d1_we)             d1_q  <= fsm_wval;
            else if (hit[REG_D1])  d1_q  <= wr_data;
            if (blk_we)            blk_q <= fsm_wval;
            else if (hit[REG_BLK]) blk_q <= wr_data;
            // write-one-to-clear, core events win
            if (hit[REG_STAT]) begin
                bd_q   <= bd_q   & ~wr_data[7];
                fail_q <= fail_q & ~wr_data[4];
                bus_q  <= bus_q  & ~wr_data[3];
                dev_q  <= dev_q  & ~wr_data[2];
                intr_q <= intr_q & ~wr_data[1];
            end
            if (set_byte_done) bd_q   <= 1'b1;
            if (start_o)       busy_q <= 1'b1;
            if (fin) begin
                busy_q <= 1'b0;
                unique case (fin_kind)
                    END_OK:   intr_q <= 1'b1;
                    END_DEV:  dev_q  <= 1'b1;
                    END_BUS:  bus_q  <= 1'b1;
                    END_FAIL: fail_q <= 1'b1;
                endcase
            end
        end
    end

    assign status_o = {bd_q, 2'b00, fail_q, bus_q, dev_q, intr_q, busy_q};
    assign last_o   = ctl_q[CTL_LAST];
    assign kill_o   = ctl_q[CTL_KILL];
    assign cmd_o    = cmd_q;
    assign addr_o   = addr_q;
    assign d0_o     = d0_q;
    assign d1_o     = d1_q;
    assign blk_o    = blk_q;
    assign irq_o    = ctl_q[CTL_IE] & (fail_q | bus_q | dev_q | intr_q);

    always_comb begin
        case (rd_addr)
            REG_STAT: rd_data = status_o;
            REG_CTL:  rd_data = ctl_q;
            REG_CMD:  rd_data = cmd_q;
            REG_ADDR: rd_data = addr_q;
            REG_D0:   rd_data = d0_q;
            REG_D1:   rd_data = d1_q;
            REG_BLK:  rd_data = blk_q;
            default:  rd_data = 8'h00;
        endcase
    end

endmodule

// File: rtl/smb_host_fsm.sv
module smb_host_fsm
    import smb_host_pkg::*;
#(
    parameter int MAX_BLOCK = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [2:0] start_type,
    input  logic       last_req,
    input  logic       kill,
    input  logic       byte_done,
    input  logic [7:0] addr,
    input  logic [7:0] cmd,
    input  logic [7:0] d0,
    input  logic [7:0] d1,
    input  logic [7:0] blk,
    output logic       eng_req,
    output eng_op_e    eng_op,
    output logic [7:0] eng_wdata,
    output logic       eng_nack,
    input  logic       eng_done,
    input  logic       eng_nak,
    input  logic       eng_fault,
    input  logic [7:0] eng_rdata,
    output logic       set_byte_done,
    output logic       fin,
    output end_e       fin_kind,
    output logic       d0_we,
    output logic       d1_we,
    output logic       blk_we,
    output logic [7:0] wval
);

    localparam int         CNT_W = $clog2(MAX_BLOCK + 1);
    localparam logic [7:0] MAX_B = 8'(MAX_BLOCK);

    function automatic logic [CNT_W-1:0] clip(input logic [7:0] v);
        return (v > MAX_B) ? CNT_W'(MAX_BLOCK) : v[CNT_W-1:0];
    endfunction

    function automatic logic type_ok(input logic [2:0] t);
        return (t != 3'd4) && (t != 3'd7);
    endfunction

    seq_state_e       state, nxt, adv;
    end_e             kind, nxt_kind;
    logic [2:0]       ttype;
    logic             trw, last_sent, ok_done, wr_phase, rblk_nack;
    logic [CNT_W-1:0] idx, total;

    assign ok_done   = eng_done && !eng_fault && !kill;
    assign wr_phase  = state inside {S_ADDR1, S_ADDR2, S_CMD, S_OFS,
                                     S_WD0, S_WD1, S_WCNT, S_WBLK};
    assign rblk_nack = (ttype == T_I2CRD) ? last_req
                                          : (CNT_W'(idx + 1'b1) == total);

    // normal successor of each bus step
    always_comb begin
        adv = S_END;
        unique case (state)
            S_START1:  adv = S_ADDR1;
            S_ADDR1: begin
                if (ttype == T_QUICK)      adv = S_STOP;
                else if (ttype == T_BYTE)  adv = trw ? S_RD0 : S_CMD;
                else if (ttype == T_I2CRD) adv = S_OFS;
                else                       adv = S_CMD;
            end
            S_CMD: begin
                if (ttype == T_BYTE)       adv = S_STOP;
                else if (ttype == T_BLOCK) adv = trw ? S_RESTART : S_WCNT;
                else                       adv = trw ? S_RESTART : S_WD0;
            end
            S_OFS:     adv = S_RESTART;
            S_RESTART: adv = S_ADDR2;
            S_ADDR2: begin
                if (ttype == T_BLOCK)      adv = S_RCNT;
                else if (ttype == T_I2CRD) adv = S_RBLK;
                else                       adv = S_RD0;
            end
            S_WD0:     adv = (ttype == T_WORD) ? S_WD1 : S_STOP;
            S_WD1:     adv = S_STOP;
            S_RD0:     adv = (ttype == T_WORD) ? S_RD1 : S_STOP;
            S_RD1:     adv = S_STOP;
            S_WCNT:    adv = (total == '0) ? S_STOP : S_WBLK;
            S_RCNT:    adv = (clip(eng_rdata) == '0) ? S_STOP : S_RBLK;
            S_WBLK:    adv = S_HOLD;
            S_RBLK:    adv = S_HOLD;
            default:   adv = S_END;
        endcase
    end

    always_comb begin
        nxt      = state;
        nxt_kind = kind;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    if (type_ok(start_type)) begin
                        nxt = S_START1; nxt_kind = END_OK;
                    end else begin
                        nxt = S_END;    nxt_kind = END_DEV;
                    end
                end
            end
            S_HOLD: begin
                if (kill) begin
                    nxt = S_STOP; nxt_kind = END_FAIL;
                end else if (!byte_done) begin
                    if (ttype == T_I2CRD) nxt = last_sent ? S_STOP : S_RBLK;
                    else if (idx == total) nxt = S_STOP;
                    else nxt = trw ? S_RBLK : S_WBLK;
                end
            end
            S_END: nxt = S_IDLE;
            default: begin
                if (eng_done) begin
                    if (eng_fault) begin
                        nxt = S_END;  nxt_kind = END_BUS;
                    end else if (state == S_STOP) begin
                        nxt = S_END;
                    end else if (kill) begin
                        nxt = S_STOP; nxt_kind = END_FAIL;
                    end else if (eng_nak && wr_phase) begin
                        nxt = S_STOP; nxt_kind = END_DEV;
                    end else begin
                        nxt = adv;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE; kind <= END_OK;
            ttype <= T_QUICK; trw <= 1'b0; last_sent <= 1'b0;
            idx   <= '0;     total <= '0;
        end else begin
            state <= nxt;
            kind  <= nxt_kind;
            if (state == S_IDLE && start) begin
                ttype     <= start_type;
                trw       <= addr[0];
                idx       <= '0;
                total     <= clip(d0);
                last_sent <= 1'b0;
            end
            if (set_byte_done)              idx       <= idx + 1'b1;
            if (ok_done && state == S_RBLK) last_sent <= eng_nack;
            if (ok_done && state == S_RCNT) total     <= clip(eng_rdata);
        end
    end

    always_comb begin
        eng_req   = !(state inside {S_IDLE, S_HOLD, S_END});
        eng_op    = OP_WRITE;
        eng_wdata = 8'h00;
        eng_nack  = 1'b0;
        unique case (state)
            S_START1, S_RESTART: eng_op = OP_START;
            S_STOP:              eng_op = OP_STOP;
            S_RD0:  begin eng_op = OP_READ; eng_nack = (ttype != T_WORD); end
            S_RD1:  begin eng_op = OP_READ; eng_nack = 1'b1; end
            S_RCNT: eng_op = OP_READ;
            S_RBLK: begin eng_op = OP_READ; eng_nack = rblk_nack; end
            S_ADDR1: eng_wdata = {addr[7:1],
                                  (ttype == T_QUICK || ttype == T_BYTE) ? trw : 1'b0};
            S_ADDR2: eng_wdata = {addr[7:1], 1'b1};
            S_CMD:   eng_wdata = cmd;
            S_OFS:   eng_wdata = d1;
            S_WD0:   eng_wdata = d0;
            S_WD1:   eng_wdata = d1;
            S_WCNT:  eng_wdata = 8'(total);
            S_WBLK:  eng_wdata = blk;
            default: eng_wdata = 8'h00;
        endcase
        set_byte_done = ok_done && ((state == S_WBLK && !eng_nak) || state == S_RBLK);
        d0_we         = ok_done && (state == S_RD0 || state == S_RCNT);
        d1_we         = ok_done && (state == S_RD1);
        blk_we        = ok_done && (state == S_RBLK);
        wval          = (state == S_RCNT) ? 8'(clip(eng_rdata)) : eng_rdata;
        fin           = (state == S_END);
        fin_kind      = kind;
    end

endmodule

// File: rtl/smb_host_seq.sv
module smb_host_seq
    import smb_host_pkg::*;
#(
    parameter int MAX_BLOCK = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    output logic       eng_req,
    output logic [1:0] eng_op,
    output logic [7:0] eng_wdata,
    output logic       eng_nack,
    input  logic       eng_done,
    input  logic       eng_nak,
    input  logic       eng_fault,
    input  logic [7:0] eng_rdata
);

    logic       start_w, last_w, kill_w, sbd_w, fin_w;
    logic       d0we_w, d1we_w, blkwe_w, busy_w;
    logic [2:0] stype_w;
    logic [7:0] cmd_w, addr_w, d0_w, d1_w, blk_w, status_w, wval_w;
    end_e       kind_w;
    eng_op_e    op_w;

    smb_host_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_we), .wr_addr(reg_addr), .wr_data(reg_wdata),
        .rd_addr(reg_addr), .rd_data(reg_rdata),
        .start_o(start_w), .start_type_o(stype_w),
        .last_o(last_w), .kill_o(kill_w),
        .cmd_o(cmd_w), .addr_o(addr_w), .d0_o(d0_w), .d1_o(d1_w),
        .blk_o(blk_w), .status_o(status_w), .irq_o(irq),
        .set_byte_done(sbd_w), .fin(fin_w), .fin_kind(kind_w),
        .d0_we(d0we_w), .d1_we(d1we_w), .blk_we(blkwe_w), .fsm_wval(wval_w)
    );

    smb_host_fsm #(.MAX_BLOCK(MAX_BLOCK)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start(start_w), .start_type(stype_w),
        .last_req(last_w), .kill(kill_w), .byte_done(status_w[7]),
        .addr(addr_w), .cmd(cmd_w), .d0(d0_w), .d1(d1_w), .blk(blk_w),
        .eng_req(eng_req), .eng_op(op_w), .eng_wdata(eng_wdata),
        .eng_nack(eng_nack), .eng_done(eng_done), .eng_nak(eng_nak),
        .eng_fault(eng_fault), .eng_rdata(eng_rdata),
        .set_byte_done(sbd_w), .fin(fin_w), .fin_kind(kind_w),
        .d0_we(d0we_w), .d1_we(d1we_w), .blk_we(blkwe_w), .wval(wval_w)
    );

    assign eng_op = op_w;
    assign busy_w = status_w[0];

endmodule

// File: rtl/smb_host_seq_chk.sv
module smb_host_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       eng_req,
    input logic       busy,
    input logic       kill,
    input logic [7:0] status,
    input logic [2:0] reg_addr,
    input logic [7:0] reg_rdata
);

    AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |-> busy); // R2

    AST_START_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 3'd1) |-> !reg_rdata[6]); // R2

    AST_FLAG_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (status[4:1] != 4'b0000)); // R3

    AST_STALL_ON_BYTE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (status[7] && !kill) |-> !eng_req); // R6

endmodule

bind smb_host_seq smb_host_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .eng_req(eng_req), .busy(busy_w),
    .kill(kill_w), .status(status_w), .reg_addr(reg_addr),
    .reg_rdata(reg_rdata)
);

// File: tb/smb_host_seq_test.sv
`timescale 1ns/1ps
module smb_host_seq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq, eng_req, eng_nack;
    logic [1:0] eng_op;
    logic [7:0] eng_wdata;
    logic       eng_done = 1'b0, eng_nak = 1'b0, eng_fault = 1'b0;
    logic [7:0] eng_rdata = 8'h00;

    int errs = 0, checks = 0;
    int log_e [32];
    int n_log = 0;
    int exp_e [32];
    int n_exp = 0;
    int nak_at = -1, fault_at = -1;
    logic [7:0] rd_q [8];
    int rd_i = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    smb_host_seq #(.MAX_BLOCK(4)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .eng_req(eng_req), .eng_op(eng_op), .eng_wdata(eng_wdata),
        .eng_nack(eng_nack), .eng_done(eng_done), .eng_nak(eng_nak),
        .eng_fault(eng_fault), .eng_rdata(eng_rdata)
    );

    // byte engine and target model
    initial begin
        forever begin
            @(negedge clk);
            if (eng_req) begin
                int k;
                k = n_log;
                if (n_log < 32)
                    log_e[n_log] = int'(eng_op) * 512 + int'(eng_nack) * 256
                                 + ((eng_op == 2'd1) ? int'(eng_wdata) : 0);
                n_log++;
                repeat (2) @(negedge clk);
                eng_fault = (k == fault_at);
                eng_nak   = (k == nak_at);
                if (eng_op == 2'd2) begin
                    eng_rdata = rd_q[rd_i % 8];
                    rd_i++;
                end
                eng_done = 1'b1;
                @(negedge clk);
                eng_done = 1'b0; eng_fault = 1'b0; eng_nak = 1'b0;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic expect_op(input int op, input int nack, input int data);
        exp_e[n_exp] = op * 512 + nack * 256 + data;
        n_exp++;
    endtask

    task automatic check_log(input string req);
        check({req, " op count"}, n_log, n_exp);
        for (int i = 0; i < n_exp && i < n_log; i++)
            check({req, " op entry"}, log_e[i], exp_e[i]);
    endtask

    task automatic fresh();
        wr_reg(3'd1, 8'h00);
        wr_reg(3'd0, 8'hFF);
        n_log = 0; n_exp = 0; nak_at = -1; fault_at = -1; rd_i = 0;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int i = 0; i < 2000; i++) begin
            rd_reg(3'd0, s);
            if (!s[0]) break;
        end
    endtask

    // poll until byte done or not busy
    task automatic poll(output logic [7:0] s);
        for (int i = 0; i < 2000; i++) begin
            rd_reg(3'd0, s);
            if (s[7] || !s[0]) break;
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int a = 0; a < 8; a++) begin
            rd_reg(3'(a), v);
            check("R1 register reset value", v, 0);
        end
        check("R1 no request after reset", eng_req, 0);
        check("R1 irq low after reset", irq, 0);
    endtask

    task automatic t_quick();
        logic [7:0] v;
        fresh();
        wr_reg(3'd3, 8'hA5);
        wr_reg(3'd1, 8'h40);
        rd_reg(3'd1, v);
        check("R2 start bit reads 0", v[6], 0);
        rd_reg(3'd0, v);
        check("R2 busy while running", v[0], 1);
        wr_reg(3'd1, 8'h40);
        wait_idle();
        repeat (10) @(negedge clk);
        expect_op(0, 0, 0); expect_op(1, 0, 8'hA5); expect_op(3, 0, 0);
        check_log("R3 quick sequence / R2 second start ignored");
        rd_reg(3'd0, v);
        check("R3 done flag after quick", v, 8'h02);
        wr_reg(3'd0, 8'h00);
        rd_reg(3'd0, v);
        check("R12 writing zero keeps flag", v, 8'h02);
        wr_reg(3'd0, 8'h02);
        rd_reg(3'd0, v);
        check("R12 writing one clears flag", v, 8'h00);
    endtask

    task automatic t_bdata_write();
        logic [7:0] v;
        fresh();
        wr_reg(3'd3, 8'h50); wr_reg(3'd2, 8'h11); wr_reg(3'd4, 8'h7E);
        wr_reg(3'd1, 8'h48);
        wait_idle();
        expect_op(0, 0, 0); expect_op(1, 0, 8'h50); expect_op(1, 0, 8'h11);
        expect_op(1, 0, 8'h7E); expect_op(3, 0, 0);
        check_log("R4 byte-data write");
        rd_reg(3'd0, v);
        check("R4 done flag", v, 8'h02);
    endtask

    task automatic t_word_read();
        logic [7:0] v;
        fresh();
        rd_q[0] = 8'h34; rd_q[1] = 8'h12;
        wr_reg(3'd3, 8'h51); wr_reg(3'd2, 8'h22);
        wr_reg(3'd1, 8'h4C);
        wait_idle();
        expect_op(0, 0, 0); expect_op(1, 0, 8'h50); expect_op(1, 0, 8'h22);
        expect_op(0, 0, 0); expect_op(1, 0, 8'h51); expect_op(2, 0, 0);
        expect_op(2, 1, 0); expect_op(3, 0, 0);
        check_log("R5 word read");
        rd_reg(3'd4, v); check("R5 data0 low byte", v, 8'h34);
        rd_reg(3'd5, v); check("R5 data1 high byte", v, 8'h12);
    endtask

    task automatic t_block_write(input int cnt, input int expn, input string req);
        logic [7:0] s;
        int done_n;
        fresh();
        done_n = 0;
        wr_reg(3'd3, 8'h40); wr_reg(3'd2, 8'h33);
        wr_reg(3'd4, 8'(cnt)); wr_reg(3'd6, 8'hA0);
        wr_reg(3'd1, 8'h54);
        for (int i = 0; i < 20; i++) begin
            poll(s);
            if (!s[7]) break;
            done_n++;
            if (done_n == 1) begin
                repeat (10) @(negedge clk);
                check({req, " stalls while byte done set"}, n_log, 5);
            end
            wr_reg(3'd6, 8'(8'hA0 + done_n));
            wr_reg(3'd0, 8'h80);
        end
        expect_op(0, 0, 0); expect_op(1, 0, 8'h40); expect_op(1, 0, 8'h33);
        expect_op(1, 0, expn);
        for (int i = 0; i < expn; i++) expect_op(1, 0, 8'hA0 + i);
        expect_op(3, 0, 0);
        check_log(req);
        check({req, " byte-done count"}, done_n, expn);
        rd_reg(3'd0, s);
        check({req, " done flag"}, s, 8'h02);
    endtask

    task automatic t_block_read();
        logic [7:0] s, v;
        int done_n;
        fresh();
        done_n = 0;
        rd_q[0] = 8'h02; rd_q[1] = 8'h5A; rd_q[2] = 8'h5B;
        wr_reg(3'd3, 8'h41); wr_reg(3'd2, 8'h33);
        wr_reg(3'd1, 8'h54);
        for (int i = 0; i < 20; i++) begin
            poll(s);
            if (!s[7]) break;
            rd_reg(3'd6, v);
            check("R7 block byte value", v, 8'h5A + done_n);
            done_n++;
            wr_reg(3'd0, 8'h80);
        end
        expect_op(0, 0, 0); expect_op(1, 0, 8'h40); expect_op(1, 0, 8'h33);
        expect_op(0, 0, 0); expect_op(1, 0, 8'h41); expect_op(2, 0, 0);
        expect_op(2, 0, 0); expect_op(2, 1, 0); expect_op(3, 0, 0);
        check_log("R7 block read");
        rd_reg(3'd4, v); check("R7 count in data0", v, 8'h02);
        check("R7 byte-done count", done_n, 2);
    endtask

    task automatic t_i2c_read();
        logic [7:0] s, v;
        int done_n;
        fresh();
        done_n = 0;
        rd_q[0] = 8'h61; rd_q[1] = 8'h62; rd_q[2] = 8'h63;
        wr_reg(3'd3, 8'hA0); wr_reg(3'd5, 8'h10);
        wr_reg(3'd1, 8'h58);
        for (int i = 0; i < 20; i++) begin
            poll(s);
            if (!s[7]) break;
            rd_reg(3'd6, v);
            check("R8 I2C byte value", v, 8'h61 + done_n);
            done_n++;
            if (done_n == 2) wr_reg(3'd1, 8'h38);
            wr_reg(3'd0, 8'h80);
        end
        expect_op(0, 0, 0); expect_op(1, 0, 8'hA0); expect_op(1, 0, 8'h10);
        expect_op(0, 0, 0); expect_op(1, 0, 8'hA1); expect_op(2, 0, 0);
        expect_op(2, 0, 0); expect_op(2, 1, 0); expect_op(3, 0, 0);
        check_log("R8 I2C block read");
        rd_reg(3'd1, v);
        check("R8 last-byte bit cleared", v, 8'h18);
    endtask

    task automatic t_nak();
        logic [7:0] v;
        fresh();
        nak_at = 1;
        wr_reg(3'd3, 8'h50); wr_reg(3'd1, 8'h48);
        wait_idle();
        expect_op(0, 0, 0); expect_op(1, 0, 8'h50); expect_op(3, 0, 0);
        check_log("R9 address NACK");
        rd_reg(3'd0, v);
        check("R9 device error only", v, 8'h04);
    endtask

    task automatic t_fault();
        logic [7:0] v;
        fresh();
        fault_at = 2;
        wr_reg(3'd3, 8'h50); wr_reg(3'd2, 8'h11); wr_reg(3'd1, 8'h48);
        wait_idle();
        expect_op(0, 0, 0); expect_op(1, 0, 8'h50); expect_op(1, 0, 8'h11);
        check_log("R10 fault, no stop");
        rd_reg(3'd0, v);
        check("R10 bus error", v, 8'h08);
    endtask

    task automatic t_kill();
        logic [7:0] s;
        fresh();
        wr_reg(3'd3, 8'h40); wr_reg(3'd2, 8'h33);
        wr_reg(3'd4, 8'h03); wr_reg(3'd6, 8'hB0);
        wr_reg(3'd1, 8'h54);
        poll(s);
        wr_reg(3'd1, 8'h56);
        wait_idle();
        expect_op(0, 0, 0); expect_op(1, 0, 8'h40); expect_op(1, 0, 8'h33);
        expect_op(1, 0, 8'h03); expect_op(1, 0, 8'hB0); expect_op(3, 0, 0);
        check_log("R11 kill");
        rd_reg(3'd0, s);
        check("R11 failed flag", int'(s & 8'h1F), 8'h10);
    endtask

    task automatic t_irq();
        fresh();
        wr_reg(3'd3, 8'hA4);
        wr_reg(3'd1, 8'h41);
        wait_idle();
        @(negedge clk);
        check("R13 irq with enable and done", irq, 1);
        wr_reg(3'd0, 8'h02);
        @(negedge clk);
        check("R13 irq after clearing flag", irq, 0);
    endtask

    task automatic t_badtype();
        logic [7:0] v;
        fresh();
        wr_reg(3'd1, 8'h50);
        repeat (10) @(negedge clk);
        check("R14 no bus activity", n_log, 0);
        rd_reg(3'd0, v);
        check("R14 device error", v, 8'h04);
        fresh();
        wr_reg(3'd1, 8'h5C);
        repeat (10) @(negedge clk);
        check("R14 type 7 no activity", n_log, 0);
        rd_reg(3'd0, v);
        check("R14 type 7 device error", v, 8'h04);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_quick();
        t_bdata_write();
        t_word_read();
        t_block_write(3, 3, "R6 block write");
        t_block_write(6, 4, "R6 block write clipped");
        t_block_read();
        t_i2c_read();
        t_nak();
        t_fault();
        t_kill();
        t_irq();
        t_badtype();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errs++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule